// File: doc/BRIEF.md
# Replica-Delay Supply Voltage Controller

This block is the digital half of a closed supply-scaling loop for an on-chip memory array. A replica bit-line completion pulse runs down a chain of buffer stages, and each stage output arrives here as one bit of a tap vector. The controller registers the vector on every clock edge and counts how many taps have switched. That count measures the timing slack left in the current clock period. When too few taps have switched, the memory is too slow, so the supply code is raised. When plenty have switched, the supply code is lowered. The goal is the lowest supply at which the read still finishes with a fixed safety margin, expressed as a number of extra buffer stages.

The supply code is the supply in 10 mV units (code = millivolts / 10). During operation it stays between 0.35 V and 1.5 V. Each step is followed by a programmable settling window so the regulator can respond before the next decision. A lock flag reports a stable operating point. A body-bias enable turns on while the chosen supply is below 0.6 V. A standby request parks the supply at 0.3 V and drives the address decoder into its cut-off state. Leaving standby restarts the search from the top of the range.

Top module: `vdd_slack_ctrl`

## Requirements
- R1: Each clock edge registers `replica_taps`. The tap count used by a decision is the number of ones in the vector registered at the previous edge, so bubbles are counted too.
- R2: In a decision cycle, the code rises by one when the tap count is below MARGIN (default 5). It falls by one when the count is above MARGIN+2. Otherwise it holds. It never changes by more than one code per edge.
- R3: While active, the code stays within 35 to 150. A step that would leave this range is suppressed and counts as a hold.
- R4: After a step, or after leaving standby, the next `settle_cycles` edges make no decision. The next decision is taken at the edge after those.
- R5: `locked` is high once 4 consecutive decisions have held the code. Any step, standby or reset clears it.
- R6: `bias_en` is high exactly when the block is active and the code is below 60 (0.6 V).
- R7: At the first edge that samples `standby_req` high, the code becomes 30 (0.3 V). At that same edge `decoder_cutoff` goes high, while `locked` and `bias_en` go low. No decision is made while in standby.
- R8: At the first edge that samples `standby_req` low after standby, the code becomes 150, `decoder_cutoff` falls and a settling window begins.
- R9: After reset, the code is 150, `bias_en`, `decoder_cutoff` and `locked` are low, and no settling window is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| replica_taps | input | 16 | Raw outputs of the replica delay buffer stages |
| settle_cycles | input | 8 | Edges with no decision after each code change |
| standby_req | input | 1 | Request for the low-leakage standby state |
| vdd_code | output | 8 | Supply request in 10 mV units |
| bias_en | output | 1 | Body-bias enable for low-supply operation |
| decoder_cutoff | output | 1 | Drives the decoder into its cut-off state |
| locked | output | 1 | Code has held for 4 consecutive decisions |

## Verification
Several tap patterns are applied. All-ones taps drive the code down to the lower limit and check that it stops there and that bias turns on. All-zero taps drive the code back up to the upper limit, where a clamped step must count as a hold. Counts at and just beyond MARGIN and MARGIN+2 are used to tell the up, hold and down bands apart. A closed-loop run makes the tap count a function of the current code and must settle and lock. Random thermometer and bubbled vectors, mixed with random settle windows and standby bursts, test whether step blocking, standby entry and standby exit interact correctly.

// File: rtl/vdd_ctrl_pkg.sv
package vdd_ctrl_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // Convert a voltage in millivolts to a supply code for a given step size.
  function automatic int mv_to_code(input int mv, input int step_mv);
    return mv / step_mv;
  endfunction

  // Width needed to hold the values 0..n.
  function automatic int count_width(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/vdd_tap_capture.sv
module vdd_tap_capture #(
  parameter int TAPS = 16,
  localparam int CW  = vdd_ctrl_pkg::count_width(TAPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TAPS-1:0] taps_raw,
  output logic [CW-1:0]   tap_count
);

  logic [TAPS-1:0] taps_q;

  // One capture flop per buffer stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps_q <= '0;
    else        taps_q <= taps_raw;
  end

  // Count the switched stages; bubbles are counted, not rejected.
  always_comb begin
    tap_count = '0;
    for (int i = 0; i < TAPS; i++) begin
      tap_count = tap_count + CW'(taps_q[i]);
    end
  end

endmodule

// File: rtl/vdd_step_policy.sv
module vdd_step_policy
  import vdd_ctrl_pkg::*;
#(
  parameter int TAPS     = 16,
  parameter int MARGIN   = 5,
  parameter int CODE_W   = 8,
  parameter int CODE_MIN = 35,
  parameter int CODE_MAX = 150,
  localparam int CW      = count_width(TAPS)
) (
  input  logic [CW-1:0]     tap_count,
  input  logic [CODE_W-1:0] cur_code,
  output step_e             step
);

  localparam logic [CW-1:0]     LO_BAND = CW'(MARGIN);
  localparam logic [CW-1:0]     HI_BAND = CW'(MARGIN + 2);
  localparam logic [CODE_W-1:0] TOP     = CODE_W'(CODE_MAX);
  localparam logic [CODE_W-1:0] BOTTOM  = CODE_W'(CODE_MIN);

  // Too little slack -> raise supply, ample slack -> lower it, clamp at limits.
  always_comb begin
    step = STEP_HOLD;
    if (tap_count < LO_BAND) begin
      if (cur_code < TOP) step = STEP_UP;
    end else if (tap_count > HI_BAND) begin
      if (cur_code > BOTTOM) step = STEP_DOWN;
    end
  end

endmodule

// File: rtl/vdd_settle_timer.sv
module vdd_settle_timer #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                load,
  input  logic [SETTLE_W-1:0] load_val,
  output logic                busy
);

  logic [SETTLE_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remain_q <= '0;
    else if (clear)            remain_q <= '0;
    else if (load)             remain_q <= load_val;
    else if (remain_q != '0)   remain_q <= remain_q - SETTLE_W'(1);
  end

  assign busy = (remain_q != '0);

  // R4: a load of a nonzero window leaves exactly that many edges to wait
  a_r4_window_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear && load_val != '0) |=> (remain_q == $past(load_val)));

  // R4: the window counts down by one per edge until it empties
  a_r4_window_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load && !clear) |=> (remain_q == $past(remain_q) - SETTLE_W'(1)));

endmodule

// File: rtl/vdd_slack_ctrl.sv
module vdd_slack_ctrl
  import vdd_ctrl_pkg::*;
#(
  parameter int TAPS       = 16,
  parameter int MARGIN     = 5,
  parameter int CODE_W     = 8,
  parameter int SETTLE_W   = 8,
  parameter int STEP_MV    = 10,
  parameter int VMIN_MV    = 350,
  parameter int VMAX_MV    = 1500,
  parameter int VSTBY_MV   = 300,
  parameter int VBIAS_MV   = 600,
  parameter int LOCK_HOLDS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TAPS-1:0]     replica_taps,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                standby_req,
  output logic [CODE_W-1:0]   vdd_code,
  output logic                bias_en,
  output logic                decoder_cutoff,
  output logic                locked
);

  localparam int CW       = count_width(TAPS);
  localparam int HW       = count_width(LOCK_HOLDS);
  localparam int CODE_MIN = mv_to_code(VMIN_MV, STEP_MV);
  localparam int CODE_MAX = mv_to_code(VMAX_MV, STEP_MV);
  localparam logic [CODE_W-1:0] C_MIN  = CODE_W'(CODE_MIN);
  localparam logic [CODE_W-1:0] C_MAX  = CODE_W'(CODE_MAX);
  localparam logic [CODE_W-1:0] C_STBY = CODE_W'(mv_to_code(VSTBY_MV, STEP_MV));
  localparam logic [CODE_W-1:0] C_BIAS = CODE_W'(mv_to_code(VBIAS_MV, STEP_MV));
  localparam logic [HW-1:0]     H_LOCK = HW'(LOCK_HOLDS);

  // Named internal events
  logic [CW-1:0]     tap_count;
  step_e             step;
  logic              settle_busy;
  logic              in_stby;
  logic              stby_exit;
  logic              decide_en;
  logic              step_fire;
  logic [CODE_W-1:0] code_q;
  logic [HW-1:0]     holds_q;

  vdd_tap_capture #(.TAPS(TAPS)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .taps_raw  (replica_taps),
    .tap_count (tap_count)
  );

  vdd_step_policy #(
    .TAPS(TAPS), .MARGIN(MARGIN), .CODE_W(CODE_W),
    .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX)
  ) u_policy (
    .tap_count (tap_count),
    .cur_code  (code_q),
    .step      (step)
  );

  assign stby_exit = in_stby && !standby_req;
  assign decide_en = !in_stby && !standby_req && !settle_busy;
  assign step_fire = decide_en && (step != STEP_HOLD);

  vdd_settle_timer #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (standby_req),
    .load     (step_fire || stby_exit),
    .load_val (settle_cycles),
    .busy     (settle_busy)
  );

  // Supply code, standby state and hold run-length
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_stby <= 1'b0;
      code_q  <= C_MAX;
      holds_q <= '0;
    end else if (standby_req) begin
      in_stby <= 1'b1;
      code_q  <= C_STBY;
      holds_q <= '0;
    end else if (in_stby) begin
      in_stby <= 1'b0;
      code_q  <= C_MAX;
      holds_q <= '0;
    end else if (decide_en) begin
      unique case (step)
        STEP_UP:   begin code_q <= code_q + CODE_W'(1); holds_q <= '0; end
        STEP_DOWN: begin code_q <= code_q - CODE_W'(1); holds_q <= '0; end
        default:   if (holds_q != H_LOCK) holds_q <= holds_q + HW'(1);
      endcase
    end
  end

  assign vdd_code       = code_q;
  assign decoder_cutoff = in_stby;
  assign bias_en        = !in_stby && (code_q < C_BIAS);
  assign locked         = (holds_q == H_LOCK);

  // R2: at most one code of movement per edge while active
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_stby && !standby_req) |=>
      ((vdd_code == $past(vdd_code)) ||
       (vdd_code == $past(vdd_code) + CODE_W'(1)) ||
       (vdd_code == $past(vdd_code) - CODE_W'(1))));

  // R3: active code stays inside the allowed range
  a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    !in_stby |-> (vdd_code >= C_MIN && vdd_code <= C_MAX));

  // R4: a nonzero settle window blocks a step at the following edge
  a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && settle_cycles != '0) |=> !step_fire);

  // R5: a step always drops the lock
  a_r5_step_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> !locked);

  // R7: standby parks the supply and cuts off the decoder
  a_r7_standby_entry: assert property (@(posedge clk) disable iff (!rst_n)
    standby_req |=> (vdd_code == C_STBY && decoder_cutoff && !locked && !bias_en));

  // R8: leaving standby restarts from the top of the range
  a_r8_standby_exit: assert property (@(posedge clk) disable iff (!rst_n)
    stby_exit |=> (vdd_code == C_MAX && !decoder_cutoff));

endmodule

// File: tb/sim_vdd_slack_ctrl.sv
module sim_vdd_slack_ctrl;

  localparam int TAPS   = 16;
  localparam int MARGIN = 5;
  localparam int C_MIN  = 35;
  localparam int C_MAX  = 150;
  localparam int C_STBY = 30;
  localparam int C_BIAS = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] replica_taps = '0;
  logic [7:0]  settle_cycles = '0;
  logic        standby_req = 1'b0;
  logic [7:0]  vdd_code;
  logic        bias_en, decoder_cutoff, locked;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // Reference state
  int m_tapq, m_code, m_settle, m_holds;
  bit m_stby;

  always #10 clk = ~clk;

  vdd_slack_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .replica_taps(replica_taps),
    .settle_cycles(settle_cycles), .standby_req(standby_req),
    .vdd_code(vdd_code), .bias_en(bias_en),
    .decoder_cutoff(decoder_cutoff), .locked(locked)
  );

  function automatic int ones(input logic [15:0] v);
    int n = 0;
    for (int i = 0; i < 16; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic [15:0] thermo(input int n);
    logic [15:0] v = '0;
    for (int i = 0; i < 16; i++) if (i < n) v[i] = 1'b1;
    return v;
  endfunction

  task automatic model_reset();
    m_tapq = 0; m_code = C_MAX; m_settle = 0; m_holds = 0; m_stby = 0;
  endtask

  // Advance the reference by one edge using the inputs now applied.
  task automatic model_edge();
    int cnt;
    cnt = m_tapq;
    m_tapq = ones(replica_taps);
    if (standby_req) begin
      m_stby = 1; m_code = C_STBY; m_holds = 0; m_settle = 0;
    end else if (m_stby) begin
      m_stby = 0; m_code = C_MAX; m_holds = 0; m_settle = int'(settle_cycles);
    end else if (m_settle != 0) begin
      m_settle--;
    end else if (cnt < MARGIN && m_code < C_MAX) begin
      m_code++; m_holds = 0; m_settle = int'(settle_cycles);
    end else if (cnt > MARGIN + 2 && m_code > C_MIN) begin
      m_code--; m_holds = 0; m_settle = int'(settle_cycles);
    end else if (m_holds < 4) begin
      m_holds++;
    end
  endtask

  task automatic check_val(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check_val("R2 R3 R4 R8 vdd_code", int'(vdd_code), m_code);
    check_val("R6 bias_en", int'(bias_en), int'(!m_stby && m_code < C_BIAS));
    check_val("R7 decoder_cutoff", int'(decoder_cutoff), int'(m_stby));
    check_val("R5 locked", int'(locked), int'(m_holds >= 4));
  endtask

  // Inputs are applied at a falling edge; results are sampled at the next one.
  task automatic cycle(input logic [15:0] taps, input int settle, input bit stby);
    replica_taps  = taps;
    settle_cycles = 8'(settle);
    standby_req   = stby;
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R9: reset values
    check_val("R9 reset vdd_code", int'(vdd_code), C_MAX);
    check_val("R9 reset bias_en", int'(bias_en), 0);
    check_val("R9 reset decoder_cutoff", int'(decoder_cutoff), 0);
    check_val("R9 reset locked", int'(locked), 0);
    rst_n = 1'b1;

    // R1 R2 R6: ample slack, walk down to the floor, bias turns on below 60
    for (int i = 0; i < 130; i++) cycle(16'hFFFF, 0, 0);
    check_val("R3 floor reached", int'(vdd_code), C_MIN);
    check_val("R6 bias at floor", int'(bias_en), 1);
    check_val("R5 locked at floor", int'(locked), 1);

    // R2: hold band edges (count MARGIN and MARGIN+2 hold)
    for (int i = 0; i < 6; i++) cycle(thermo(MARGIN), 0, 0);
    for (int i = 0; i < 6; i++) cycle(thermo(MARGIN + 2), 0, 0);
    check_val("R2 hold band keeps code", int'(vdd_code), C_MIN);

    // R2: count MARGIN-1 steps up, bubbled vector with same count
    for (int i = 0; i < 4; i++) cycle(thermo(MARGIN - 1), 0, 0);
    for (int i = 0; i < 4; i++) cycle(16'h0A05, 0, 0);

    // R4: settling window of 5 edges between steps
    for (int i = 0; i < 30; i++) cycle(16'h0000, 5, 0);

    // R3: starve slack, climb to the ceiling and hold there
    for (int i = 0; i < 130; i++) cycle(16'h0000, 0, 0);
    check_val("R3 ceiling reached", int'(vdd_code), C_MAX);
    check_val("R5 clamped step counts as hold", int'(locked), 1);

    // R7 R8: standby entry and exit
    for (int i = 0; i < 4; i++) cycle(16'hFFFF, 2, 1);
    check_val("R7 standby code", int'(vdd_code), C_STBY);
    check_val("R7 decoder cut off", int'(decoder_cutoff), 1);
    for (int i = 0; i < 6; i++) cycle(16'hFFFF, 2, 0);

    // Closed loop: tap count follows the code, expect settle and lock
    for (int i = 0; i < 200; i++) begin
      int n;
      n = (m_code - 40) / 8;
      if (n < 0) n = 0;
      if (n > 16) n = 16;
      cycle(thermo(n), 1, 0);
    end
    check_val("R5 closed loop locks", int'(locked), 1);

    // Random mix of thermometer/bubbled taps, settle windows and standby
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] t;
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 7) t = thermo(int'($urandom_range(0, 16)));
      else       t = 16'($urandom());
      cycle(t, int'($urandom_range(0, 3)), ($urandom_range(0, 99) < 3));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule